// File: doc/BRIEF.md
# Output Compare and PWM Channel

This block is a single compare channel of a general-purpose timer. The timer core supplies it with the counter value, the count direction and the update event. The channel compares the count against its active compare value and shapes a reference waveform from that comparison. Eight modes are available: a timing-base mode that leaves the waveform alone, set-on-match, clear-on-match, toggle-on-match, two forced levels, and two PWM modes whose comparison sense follows the count direction. The pin output is the reference after a polarity choice, and it is gated by a channel enable.

The compare value is written through a shadow register. With preload off, a write reaches the active compare value at the next clock edge. With preload on, the written value waits in the shadow until an update event moves it across. A one-cycle match pulse reports count-equals-compare. A direction-select field limits the pulse to up-counting, to down-counting, or to either direction, so it can follow the timer's center-aligned setting.

The reference is held in a two-state machine, ST_LOW and ST_HIGH. The machine moves from ST_LOW to ST_HIGH on a set-match, on a toggle-match, on force-high, or when a PWM mode asks for the active level (the PWM-active transition). It moves from ST_HIGH to ST_LOW on a clear-match, on a toggle-match, on force-low, or when a PWM mode asks for the inactive level (the PWM-inactive transition). In every other case it holds its state, and frozen mode always holds.

Top module: `oc_pwm_channel`

## Requirements
- R1: While reset is asserted, and after it is released, oc_ref is 0 and match_flag is 0. The active compare value and the shadow are both 0.
- R2: In mode 0 (frozen), oc_ref keeps its value whatever the count does, including when the count equals the compare value.
- R3: In mode 1, oc_ref becomes 1 on the clock edge that follows a cycle in which the count equals the active compare value. In mode 2, it becomes 0 on that edge. Without a match it keeps its value.
- R4: In mode 3 (toggle), oc_ref inverts on the clock edge after each cycle in which the count equals the active compare value.
- R5: In mode 4, oc_ref is 0 one edge later, and in mode 5 it is 1 one edge later, regardless of the count.
- R6: In mode 6 (PWM 1), the next oc_ref is 1 when cnt_down=0 and count < compare. It is also 1 when cnt_down=1 and count <= compare. In every other case it is 0.
- R7: In mode 7 (PWM 2), the next oc_ref is the inverse of the mode 6 result for the same count, direction and compare value.
- R8: When cfg_en=1, oc_pin equals oc_ref XOR cfg_pol. When cfg_en=0, oc_pin equals cfg_pol, which is the inactive level.
- R9: When cfg_preload=0, a compare write takes effect at the next edge. When cfg_preload=1, the value written sits in the shadow and becomes active only on an edge where upd_evt=1. Until then, matching uses the old value.
- R10: match_flag is 1 for the cycle after a cycle with count equal to the active compare value, provided the direction is allowed by flag_dirsel. The encodings are 00 (either direction), 01 (down only), 10 (up only) and 11 (either direction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt | input | CNT_W | Timer count value |
| cnt_down | input | 1 | 1 while the timer counts down |
| upd_evt | input | 1 | Timer update event, one cycle |
| cfg_mode | input | 3 | Channel mode, 0 to 7 as in R2 to R7 |
| cfg_pol | input | 1 | 1 inverts the pin |
| cfg_en | input | 1 | Channel output enable |
| cfg_preload | input | 1 | Compare preload enable |
| flag_dirsel | input | 2 | Directions in which the match flag may set |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | CNT_W | Compare write value |
| oc_ref | output | 1 | Reference waveform |
| oc_pin | output | 1 | Polarity-adjusted, gated output |
| match_flag | output | 1 | One-cycle match pulse |

## Verification
The hardest case to reach is a preloaded compare value that differs from the active one while the count crosses both values. Only that case shows whether matching and PWM use the old value until the update event arrives. The stimulus sets up this case as follows:
- It enables preload and writes a new compare value in the middle of a count sweep.
- It keeps sweeping without an update, so that only the old value can produce a match.
- It then pulses the update event and sweeps again, so that only the new value can match.

The stimulus also runs PWM sweeps in both directions through the compare value, including a compare value of zero. This shows the direction-dependent comparison at the boundary where count equals compare.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        OC_FROZEN   = 3'd0,
        OC_SET_MT   = 3'd1,
        OC_CLR_MT   = 3'd2,
        OC_TOGGLE   = 3'd3,
        OC_FORCE_LO = 3'd4,
        OC_FORCE_HI = 3'd5,
        OC_PWM_A    = 3'd6,
        OC_PWM_B    = 3'd7
    } oc_mode_e;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } ref_state_e;

    typedef enum logic [1:0] {
        DIR_ANY0 = 2'b00,
        DIR_DOWN = 2'b01,
        DIR_UP   = 2'b10,
        DIR_ANY1 = 2'b11
    } flag_dir_e;

endpackage

// File: rtl/oc_cmp_shadow.sv
module oc_cmp_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preload,
    input  logic             upd_evt,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cmp_act
);

    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (wr) begin
                shadow_q <= wdata;
            end
            if (!preload && wr) begin
                act_q <= wdata;
            end else if (preload && upd_evt) begin
                act_q <= shadow_q;
            end
        end
    end

    assign cmp_act = act_q;

    AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (preload && !upd_evt) |=> $stable(cmp_act)); // R9

    AST_PRELOAD_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload && wr) |=> (cmp_act == $past(wdata))); // R9

endmodule

// File: rtl/oc_match.sv
module oc_match
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic             cnt_down,
    input  logic [1:0]       dirsel,
    output logic             eq,
    output logic             lt,
    output logic             gt,
    output logic             flag
);

    logic dir_ok;
    logic flag_q;

    assign eq = (cnt == cmp_act);
    assign lt = (cnt < cmp_act);
    assign gt = (cnt > cmp_act);

    always_comb begin
        unique case (flag_dir_e'(dirsel))
            DIR_DOWN: dir_ok = cnt_down;
            DIR_UP:   dir_ok = !cnt_down;
            DIR_ANY0,
            DIR_ANY1: dir_ok = 1'b1;
            default:  dir_ok = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= eq && dir_ok;
        end
    end

    assign flag = flag_q;

    AST_FLAG_UP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (dirsel == 2'b10 && cnt_down) |=> !flag); // R10

    AST_FLAG_DOWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (dirsel == 2'b01 && !cnt_down) |=> !flag); // R10

    AST_FLAG_NEEDS_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        !eq |=> !flag); // R10

endmodule

// File: rtl/oc_ref_fsm.sv
module oc_ref_fsm
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       cnt_down,
    input  logic       eq,
    input  logic       lt,
    input  logic       gt,
    output logic       ref_out
);

    ref_state_e state_q;
    ref_state_e state_d;
    logic       pwm_on;

    // PWM 1 active level: below compare when counting up, not above it when counting down
    assign pwm_on = cnt_down ? !gt : lt;

    always_comb begin
        state_d = state_q;
        unique case (oc_mode_e'(mode))
            OC_FROZEN:   state_d = state_q;
            OC_SET_MT:   if (eq) state_d = ST_HIGH;
            OC_CLR_MT:   if (eq) state_d = ST_LOW;
            OC_TOGGLE:   if (eq) state_d = (state_q == ST_HIGH) ? ST_LOW : ST_HIGH;
            OC_FORCE_LO: state_d = ST_LOW;
            OC_FORCE_HI: state_d = ST_HIGH;
            OC_PWM_A:    state_d = pwm_on ? ST_HIGH : ST_LOW;
            OC_PWM_B:    state_d = pwm_on ? ST_LOW : ST_HIGH;
            default:     state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ref_out = (state_q == ST_HIGH);
    end

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |=> (ref_out == $past(ref_out))); // R2

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && eq) |=> (ref_out != $past(ref_out))); // R4

    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |=> !ref_out); // R5

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5) |=> ref_out); // R5

    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && eq) |=> ref_out); // R3

endmodule

// File: rtl/oc_pwm_channel.sv
module oc_pwm_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_down,
    input  logic             upd_evt,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_pol,
    input  logic             cfg_en,
    input  logic             cfg_preload,
    input  logic [1:0]       flag_dirsel,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic             oc_ref,
    output logic             oc_pin,
    output logic             match_flag
);

    logic [CNT_W-1:0] cmp_act;
    logic             eq;
    logic             lt;
    logic             gt;

    oc_cmp_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .preload (cfg_preload),
        .upd_evt (upd_evt),
        .wr      (cmp_wr),
        .wdata   (cmp_wdata),
        .cmp_act (cmp_act)
    );

    oc_match #(.CNT_W(CNT_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .cmp_act  (cmp_act),
        .cnt_down (cnt_down),
        .dirsel   (flag_dirsel),
        .eq       (eq),
        .lt       (lt),
        .gt       (gt),
        .flag     (match_flag)
    );

    oc_ref_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cfg_mode),
        .cnt_down (cnt_down),
        .eq       (eq),
        .lt       (lt),
        .gt       (gt),
        .ref_out  (oc_ref)
    );

    assign oc_pin = cfg_en ? (oc_ref ^ cfg_pol) : cfg_pol;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!oc_ref && !match_flag)); // R1

endmodule

// File: tb/oc_pwm_channel_tb.sv
module oc_pwm_channel_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    typedef struct {
        logic  e_ref;
        logic  e_pin;
        logic  e_flag;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic          cnt_down = 1'b0;
    logic          upd_evt = 1'b0;
    logic [2:0]    cfg_mode = 3'd0;
    logic          cfg_pol = 1'b0;
    logic          cfg_en = 1'b0;
    logic          cfg_preload = 1'b0;
    logic [1:0]    flag_dirsel = 2'b00;
    logic          cmp_wr = 1'b0;
    logic [CW-1:0] cmp_wdata = '0;
    logic          oc_ref;
    logic          oc_pin;
    logic          match_flag;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];

    logic [2:0]    c_mode = 3'd0;
    logic          c_pol = 1'b0;
    logic          c_en = 1'b1;
    logic          c_pre = 1'b0;
    logic [1:0]    c_dsel = 2'b00;
    logic          m_ref = 1'b0;
    logic [CW-1:0] m_act = '0;
    logic [CW-1:0] m_shadow = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_pwm_channel #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_down(cnt_down),
        .upd_evt(upd_evt), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol),
        .cfg_en(cfg_en), .cfg_preload(cfg_preload), .flag_dirsel(flag_dirsel),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .oc_ref(oc_ref),
        .oc_pin(oc_pin), .match_flag(match_flag)
    );

    task automatic check1(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // monitor: pop one expected item per clock edge and compare
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check1(it.tag, oc_ref, it.e_ref, "oc_ref");
            check1(it.tag, oc_pin, it.e_pin, "oc_pin");
            check1(it.tag, match_flag, it.e_flag, "match_flag");
        end
    end

    // driver: apply one cycle of stimulus and push the expected result
    task automatic step(input logic [CW-1:0] c, input logic dn, input logic up,
                        input logic wr, input logic [CW-1:0] wd, input string tag);
        logic eq, nref, pwm1, dok;
        exp_t it;
        @(negedge clk);
        cnt = c; cnt_down = dn; upd_evt = up; cmp_wr = wr; cmp_wdata = wd;
        cfg_mode = c_mode; cfg_pol = c_pol; cfg_en = c_en;
        cfg_preload = c_pre; flag_dirsel = c_dsel;
        eq = (c == m_act);
        pwm1 = dn ? (c <= m_act) : (c < m_act);
        case (c_mode)
            3'd1: nref = eq ? 1'b1 : m_ref;
            3'd2: nref = eq ? 1'b0 : m_ref;
            3'd3: nref = eq ? ~m_ref : m_ref;
            3'd4: nref = 1'b0;
            3'd5: nref = 1'b1;
            3'd6: nref = pwm1;
            3'd7: nref = ~pwm1;
            default: nref = m_ref;
        endcase
        case (c_dsel)
            2'b01: dok = dn;
            2'b10: dok = ~dn;
            default: dok = 1'b1;
        endcase
        it.e_ref = nref;
        it.e_pin = c_en ? (nref ^ c_pol) : c_pol;
        it.e_flag = eq & dok;
        it.tag = tag;
        sb.push_back(it);
        m_ref = nref;
        if (wr) m_shadow = wd;
        if (!c_pre && wr) m_act = wd;
        else if (c_pre && up) m_act = m_shadow;
    endtask

    task automatic sweep(input int a, input int b, input logic dn, input string tag);
        if (a <= b) begin
            for (int i = a; i <= b; i++) step(CW'(i), dn, 1'b0, 1'b0, '0, tag);
        end else begin
            for (int i = a; i >= b; i--) step(CW'(i), dn, 1'b0, 1'b0, '0, tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        check1("R1", oc_ref, 1'b0, "oc_ref in reset");
        check1("R1", match_flag, 1'b0, "match_flag in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check1("R1", oc_ref, 1'b0, "oc_ref after reset");
        check1("R1", oc_pin, 1'b0, "oc_pin after reset");

        // compare value 0 after reset: match at count 0
        c_mode = 3'd1;
        sweep(3, 0, 1'b1, "R1");

        // direct compare write of 5
        c_mode = 3'd4;
        step(16'd0, 1'b0, 1'b0, 1'b1, 16'd5, "R9");
        c_mode = 3'd1;
        sweep(0, 7, 1'b0, "R3");
        c_mode = 3'd2;
        sweep(0, 7, 1'b0, "R3");

        c_mode = 3'd5;
        step(16'd1, 1'b0, 1'b0, 1'b0, '0, "R5");
        c_mode = 3'd0;
        sweep(3, 7, 1'b0, "R2");
        c_mode = 3'd4;
        step(16'd5, 1'b0, 1'b0, 1'b0, '0, "R5");
        c_mode = 3'd0;
        sweep(4, 6, 1'b1, "R2");

        c_mode = 3'd3;
        sweep(0, 7, 1'b0, "R4");
        sweep(7, 0, 1'b1, "R4");
        sweep(0, 7, 1'b0, "R4");

        c_mode = 3'd6;
        sweep(0, 9, 1'b0, "R6");
        sweep(9, 0, 1'b1, "R6");
        c_mode = 3'd7;
        sweep(0, 9, 1'b0, "R7");
        sweep(9, 0, 1'b1, "R7");

        // polarity and enable
        c_mode = 3'd6; c_pol = 1'b1;
        sweep(2, 7, 1'b0, "R8");
        c_en = 1'b0;
        sweep(2, 7, 1'b0, "R8");
        c_pol = 1'b0;
        sweep(2, 7, 1'b0, "R8");
        c_en = 1'b1;

        // preload: new value 8 waits for update
        c_pre = 1'b1; c_mode = 3'd1;
        step(16'd0, 1'b0, 1'b0, 1'b1, 16'd8, "R9");
        c_mode = 3'd2;
        sweep(4, 9, 1'b0, "R9");
        c_mode = 3'd1;
        sweep(0, 9, 1'b0, "R9");
        c_mode = 3'd2;
        step(16'd9, 1'b0, 1'b1, 1'b0, '0, "R9");
        c_mode = 3'd1;
        sweep(0, 9, 1'b0, "R9");
        c_mode = 3'd6;
        sweep(6, 9, 1'b0, "R9");
        c_pre = 1'b0;

        // compare 0 boundary for PWM
        c_mode = 3'd6;
        step(16'd3, 1'b0, 1'b0, 1'b1, 16'd0, "R6");
        sweep(0, 3, 1'b0, "R6");
        sweep(3, 0, 1'b1, "R6");
        step(16'd4, 1'b0, 1'b0, 1'b1, 16'd5, "R6");

        // flag direction select
        c_mode = 3'd0;
        for (int d = 0; d < 4; d++) begin
            c_dsel = 2'(d);
            sweep(3, 7, 1'b0, "R10");
            sweep(7, 3, 1'b1, "R10");
        end

        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule